// File: doc/BRIEF.md
# Multiplier Stage with Mode-Dependent Range Check

This block is the front half of a multiply-accumulate unit. It takes two 32-bit operands, multiplies them at full 64-bit precision, and presents a 40-bit product to the accumulate step that follows. The operands can be read as signed integers, unsigned integers or signed 1.31 fractions. The result is checked against the 40-bit field using the rule for the selected mode. A fractional product can be rounded, with ties going to even. When overflow is detected, the block reports it with a one-cycle pulse. That pulse feeds a sticky overflow bit kept elsewhere.

Software can also ask for overflow to be forced onward. In that case an overflowing product is replaced by a saturated value, and a second pulse tells the downstream adder to treat its result as overflowed. Each operand pair is accepted on a single-cycle valid strobe. The product register keeps its value until the next accepted pair.

Top module: `macMultStage`

## Requirements
- R1: While reset is asserted and after it is released, `outValid`, `ovfPulse` and `forceAccOvf` are 0 and `product` is 0 until the first accepted input.
- R2: An input accepted with `inValid`=1 at a clock edge produces `outValid`=1 for exactly the next cycle, with that input's result on `product`, `ovfPulse` and `forceAccOvf`. Consecutive valid inputs give consecutive results. `ovfPulse` and `forceAccOvf` are 0 in any cycle where `outValid` is 0.
- R3: With `mode`=2'b00 (signed integer), `product` is bits 39..0 of the 64-bit two's-complement product. `ovfPulse` is 1 when the 64-bit product differs from those 40 bits sign-extended.
- R4: With `mode`=2'b01 (unsigned integer), `product` is bits 39..0 of the 64-bit unsigned product. `ovfPulse` is 1 when any of bits 63..40 of that product is set.
- R5: With `mode`=2'b10 (fractional) and `roundEn`=0, the 64-bit signed product is doubled and `product` is bits 63..24 of the doubled value. The low 24 bits are dropped, which rounds toward minus infinity.
- R6: In fractional mode with `roundEn`=1, the low 24 bits of the doubled product are the remainder, and bit 24 is the kept LSB. A remainder above 0x800000 adds one kept LSB. A remainder equal to 0x800000 adds one only when the kept LSB is 1. Any other remainder adds nothing.
- R7: In fractional mode, `ovfPulse` is 1 when the doubled and rounded value does not fit a 64-bit signed number, for example when both operands are 0x80000000. In that case `product` is bits 63..24 of the wrapped value.
- R8: When a result overflows and `ovfForceEn`=1, `forceAccOvf` pulses together with `ovfPulse`. `product` is then replaced as follows: 0xFFFFFFFFFF in unsigned mode, and in signed and fractional modes 0x7FFFFFFFFF when the exact result is positive or 0x8000000000 when it is negative. Without overflow, `ovfForceEn` has no effect.
- R9: While `inValid`=0, `product` holds its last value whatever the other inputs do.
- R10: `roundEn` has no effect in the integer modes.
- R11: `mode`=2'b11 behaves exactly like signed integer mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Accept the operands and controls this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| mode | input | 2 | 00 signed int, 01 unsigned int, 10 signed fraction, 11 signed int |
| roundEn | input | 1 | Round fractional products, ties to even |
| ovfForceEn | input | 1 | Saturate overflowing products and request accumulate overflow |
| outValid | output | 1 | New result present this cycle |
| product | output | 40 | Registered product, held between results |
| ovfPulse | output | 1 | The result overflowed the 40-bit field |
| forceAccOvf | output | 1 | The following accumulate must overflow |

## Verification
The bench builds the block with its default parameters: 32-bit operands, a 40-bit product field and therefore a 24-bit rounding remainder. With these values, simple operand pairs such as 2^20 by 2^19 land exactly on the signed 40-bit edge, and a factor of 0x400000 lands exactly on the 0x800000 rounding tie. Both sides of every range boundary, and both parities of the tie, can therefore be written as short constants. The single corner where fractional doubling itself overflows, the product of 0x80000000 with itself, is also covered with and without saturation.

// File: rtl/macMultPkg.sv
package macMultPkg;

  typedef enum logic [1:0] {
    MODE_SINT = 2'b00,
    MODE_UINT = 2'b01,
    MODE_FRAC = 2'b10,
    MODE_SALT = 2'b11
  } multModeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic selUns;
    logic selFrac;
    logic rndOn;
    logic forceOn;
  } multStrobeT;

endpackage

// File: rtl/macMultCtrl.sv
module macMultCtrl
  import macMultPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] mode,
  input  logic       roundEn,
  input  logic       ovfForceEn,
  output multStrobeT str,
  output logic       outValid
);

  multModeT modeSel;
  assign modeSel = multModeT'(mode);

  always_comb begin
    str         = '0;
    str.load    = inValid;
    str.forceOn = ovfForceEn;
    unique case (modeSel)
      MODE_UINT: str.selUns = 1'b1;
      MODE_FRAC: begin
        str.selFrac = 1'b1;
        str.rndOn   = roundEn;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  out_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  out_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/macMultDatapath.sv
module macMultDatapath
  import macMultPkg::*;
#(
  parameter int OP_W   = 32,
  parameter int PROD_W = 40
)(
  input  logic              clk,
  input  logic              rstN,
  input  multStrobeT        str,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [PROD_W-1:0] prodQ,
  output logic              ovfQ,
  output logic              forceQ
);

  localparam int FULL_W = 2 * OP_W;
  localparam int REM_W  = FULL_W - PROD_W;
  localparam int DBL_W  = FULL_W + 2;
  localparam logic [REM_W-1:0] HALF = REM_W'(1) << (REM_W - 1);

  logic signed [FULL_W-1:0] sProd;
  logic        [FULL_W-1:0] uProd;
  logic signed [DBL_W-1:0]  fracDbl;
  logic signed [DBL_W-1:0]  fracRnd;
  logic        [REM_W-1:0]  remBits;
  logic                     keptLsb;
  logic                     roundUp;
  logic                     sOvf, uOvf, fOvf, ovfNow, negNow;
  logic        [PROD_W-1:0] rawVal, satVal, nextVal;

  assign sProd = $signed({{OP_W{opA[OP_W-1]}}, opA}) * $signed({{OP_W{opB[OP_W-1]}}, opB});
  assign uProd = {{OP_W{1'b0}}, opA} * {{OP_W{1'b0}}, opB};

  // Fraction: one extra sign bit, then doubled
  assign fracDbl = {sProd[FULL_W-1], sProd, 1'b0};
  assign remBits = fracDbl[REM_W-1:0];
  assign keptLsb = fracDbl[REM_W];
  assign roundUp = str.rndOn && ((remBits > HALF) || ((remBits == HALF) && keptLsb));
  assign fracRnd = fracDbl + (roundUp ? (DBL_W'(1) << REM_W) : DBL_W'(0));

  assign sOvf = sProd != {{REM_W{sProd[PROD_W-1]}}, sProd[PROD_W-1:0]};
  assign uOvf = |uProd[FULL_W-1:PROD_W];
  assign fOvf = !((fracRnd[DBL_W-1:FULL_W-1] == '0) || (fracRnd[DBL_W-1:FULL_W-1] == '1));

  always_comb begin
    if (str.selUns) begin
      rawVal = uProd[PROD_W-1:0];
      ovfNow = uOvf;
      negNow = 1'b0;
    end else if (str.selFrac) begin
      rawVal = fracRnd[FULL_W-1 -: PROD_W];
      ovfNow = fOvf;
      negNow = fracRnd[DBL_W-1];
    end else begin
      rawVal = sProd[PROD_W-1:0];
      ovfNow = sOvf;
      negNow = sProd[FULL_W-1];
    end
  end

  assign satVal  = str.selUns ? '1 :
                   negNow     ? {1'b1, {(PROD_W-1){1'b0}}} :
                                {1'b0, {(PROD_W-1){1'b1}}};
  assign nextVal = (ovfNow && str.forceOn) ? satVal : rawVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ  <= '0;
      ovfQ   <= 1'b0;
      forceQ <= 1'b0;
    end else begin
      ovfQ   <= str.load && ovfNow;
      forceQ <= str.load && ovfNow && str.forceOn;
      if (str.load) prodQ <= nextVal;
    end
  end

  // R9
  hold_prod_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.load |=> $stable(prodQ));
  // R2
  ovf_needs_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |-> $past(str.load));
  // R8
  force_implies_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceQ |-> ovfQ);
  // R8
  uns_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceQ && $past(str.selUns)) |-> (prodQ == '1));

endmodule

// File: rtl/macMultStage.sv
module macMultStage
  import macMultPkg::*;
#(
  parameter int OP_W   = 32,
  parameter int PROD_W = 40
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [1:0]        mode,
  input  logic              roundEn,
  input  logic              ovfForceEn,
  output logic              outValid,
  output logic [PROD_W-1:0] product,
  output logic              ovfPulse,
  output logic              forceAccOvf
);

  multStrobeT str;

  macMultCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .mode       (mode),
    .roundEn    (roundEn),
    .ovfForceEn (ovfForceEn),
    .str        (str),
    .outValid   (outValid)
  );

  macMultDatapath #(.OP_W(OP_W), .PROD_W(PROD_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .str    (str),
    .opA    (opA),
    .opB    (opB),
    .prodQ  (product),
    .ovfQ   (ovfPulse),
    .forceQ (forceAccOvf)
  );

endmodule

// File: tb/macMultStage_test.sv
`timescale 1ns/1ps
module macMultStage_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  mode = '0;
  logic        roundEn = 1'b0, ovfForceEn = 1'b0;
  logic        outValid, ovfPulse, forceAccOvf;
  logic [39:0] product;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  macMultStage uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .mode(mode), .roundEn(roundEn), .ovfForceEn(ovfForceEn),
    .outValid(outValid), .product(product), .ovfPulse(ovfPulse),
    .forceAccOvf(forceAccOvf)
  );

  // {req[3:0], mode[1:0], rnd, frc, a[31:0], b[31:0], exp[39:0], ovf, fa}
  localparam int NV = 28;
  localparam logic [113:0] VEC [NV] = '{
    {4'd3, 2'd0, 1'b0, 1'b0, 32'h00000003, 32'h00000005, 40'h000000000F, 1'b0, 1'b0}, // R3
    {4'd3, 2'd0, 1'b0, 1'b0, 32'hFFFFFFFD, 32'h00000005, 40'hFFFFFFFFF1, 1'b0, 1'b0}, // R3
    {4'd3, 2'd0, 1'b0, 1'b0, 32'h80000000, 32'h80000000, 40'h0000000000, 1'b1, 1'b0}, // R3
    {4'd3, 2'd0, 1'b0, 1'b0, 32'h00100000, 32'h00080000, 40'h8000000000, 1'b1, 1'b0}, // R3
    {4'd3, 2'd0, 1'b0, 1'b0, 32'h00100000, 32'h0007FFFF, 40'h7FFFF00000, 1'b0, 1'b0}, // R3
    {4'd3, 2'd0, 1'b0, 1'b0, 32'hFFF00000, 32'h00080000, 40'h8000000000, 1'b0, 1'b0}, // R3
    {4'd8, 2'd0, 1'b0, 1'b1, 32'h80000000, 32'h80000000, 40'h7FFFFFFFFF, 1'b1, 1'b1}, // R8
    {4'd8, 2'd0, 1'b0, 1'b1, 32'h80000000, 32'h7FFFFFFF, 40'h8000000000, 1'b1, 1'b1}, // R8
    {4'd8, 2'd0, 1'b0, 1'b1, 32'h00000003, 32'h00000005, 40'h000000000F, 1'b0, 1'b0}, // R8
    {4'd4, 2'd1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 40'hFE00000001, 1'b1, 1'b0}, // R4
    {4'd4, 2'd1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000100, 40'hFFFFFFFF00, 1'b0, 1'b0}, // R4
    {4'd4, 2'd1, 1'b0, 1'b0, 32'hFFFFFFFD, 32'h00000005, 40'h04FFFFFFF1, 1'b0, 1'b0}, // R4
    {4'd8, 2'd1, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h00000101, 40'hFFFFFFFFFF, 1'b1, 1'b1}, // R8
    {4'd5, 2'd2, 1'b0, 1'b0, 32'h40000000, 32'h40000000, 40'h2000000000, 1'b0, 1'b0}, // R5
    {4'd5, 2'd2, 1'b0, 1'b0, 32'hC0000000, 32'h40000000, 40'hE000000000, 1'b0, 1'b0}, // R5
    {4'd5, 2'd2, 1'b0, 1'b0, 32'h00000003, 32'h00400000, 40'h0000000001, 1'b0, 1'b0}, // R5
    {4'd5, 2'd2, 1'b0, 1'b0, 32'h00000001, 32'h00400001, 40'h0000000000, 1'b0, 1'b0}, // R5
    {4'd5, 2'd2, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00400000, 40'hFFFFFFFFFF, 1'b0, 1'b0}, // R5
    {4'd6, 2'd2, 1'b1, 1'b0, 32'h00000001, 32'h00400000, 40'h0000000000, 1'b0, 1'b0}, // R6 tie, even
    {4'd6, 2'd2, 1'b1, 1'b0, 32'h00000003, 32'h00400000, 40'h0000000002, 1'b0, 1'b0}, // R6 tie, odd
    {4'd6, 2'd2, 1'b1, 1'b0, 32'h00000001, 32'h00400001, 40'h0000000001, 1'b0, 1'b0}, // R6 above
    {4'd6, 2'd2, 1'b1, 1'b0, 32'h00000001, 32'h003FFFFF, 40'h0000000000, 1'b0, 1'b0}, // R6 below
    {4'd6, 2'd2, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00400000, 40'h0000000000, 1'b0, 1'b0}, // R6 negative tie
    {4'd7, 2'd2, 1'b0, 1'b0, 32'h80000000, 32'h80000000, 40'h8000000000, 1'b1, 1'b0}, // R7
    {4'd7, 2'd2, 1'b1, 1'b1, 32'h80000000, 32'h80000000, 40'h7FFFFFFFFF, 1'b1, 1'b1}, // R7 with R8
    {4'd10, 2'd0, 1'b1, 1'b0, 32'h00000001, 32'h00800000, 40'h0000800000, 1'b0, 1'b0}, // R10
    {4'd11, 2'd3, 1'b0, 1'b0, 32'hFFFFFFFD, 32'h00000005, 40'hFFFFFFFFF1, 1'b0, 1'b0}, // R11
    {4'd11, 2'd3, 1'b1, 1'b0, 32'h80000000, 32'h80000000, 40'h0000000000, 1'b1, 1'b0}  // R11
  };

  task automatic check(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic r, input logic f,
                       input logic [31:0] a, input logic [31:0] b);
    mode = m; roundEn = r; ovfForceEn = f; opA = a; opB = b; inValid = 1'b1;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [39:0] held;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "outValid in reset", 40'(outValid), 40'h0);
    check("R1", "product in reset", product, 40'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "flags after reset", {38'h0, ovfPulse, forceAccOvf}, 40'h0);
    check("R1", "outValid after reset", 40'(outValid), 40'h0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][113:110]);
      @(negedge clk);
      drive(VEC[i][109:108], VEC[i][107], VEC[i][106], VEC[i][105:74], VEC[i][73:42]);
      @(negedge clk);
      inValid = 1'b0;
      check("R2", $sformatf("outValid vec %0d", i), 40'(outValid), 40'h1);
      check(rq, $sformatf("product vec %0d", i), product, VEC[i][41:2]);
      check(rq, $sformatf("ovfPulse vec %0d", i), 40'(ovfPulse), 40'(VEC[i][1]));
      check(rq, $sformatf("forceAccOvf vec %0d", i), 40'(forceAccOvf), 40'(VEC[i][0]));
    end

    // R2: pulses drop after one cycle
    @(negedge clk);
    check("R2", "outValid drops", 40'(outValid), 40'h0);
    check("R2", "ovfPulse drops", 40'(ovfPulse), 40'h0);
    check("R2", "forceAccOvf drops", 40'(forceAccOvf), 40'h0);

    // R2: back-to-back inputs
    drive(2'd0, 1'b0, 1'b0, 32'd7, 32'd6);
    @(negedge clk);
    check("R2", "first of pair valid", 40'(outValid), 40'h1);
    check("R2", "first of pair product", product, 40'd42);
    drive(2'd1, 1'b0, 1'b0, 32'd9, 32'd9);
    @(negedge clk);
    inValid = 1'b0;
    check("R2", "second of pair valid", 40'(outValid), 40'h1);
    check("R2", "second of pair product", product, 40'd81);

    // R9: hold while idle
    held = product;
    for (int k = 0; k < 4; k++) begin
      mode = 2'(k); opA = 32'hFFFFFFFF; opB = 32'h12345678; roundEn = 1'b1; ovfForceEn = 1'b1;
      @(negedge clk);
      check("R9", "product held", product, held);
      check("R9", "no pulse while idle", {38'h0, ovfPulse, forceAccOvf}, 40'h0);
    end

    // R1: reset in mid run clears state
    rstN = 1'b0;
    drive(2'd0, 1'b0, 1'b0, 32'h80000000, 32'h80000000);
    @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check("R1", "product after mid reset", product, 40'h0);
    check("R1", "outValid after mid reset", 40'(outValid), 40'h0);
    check("R1", "ovfPulse after mid reset", 40'(ovfPulse), 40'h0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule